// File: doc/BRIEF.md
# Partially Parallel Sum Reducer

This block adds up a group of `TOTAL` values of `WIDTH` bits each. The values arrive `LANES` at a time, one slice per clock, so a group takes `TOTAL/LANES` cycles. A balanced adder tree sums the lanes of one slice. An accumulator register carries the running total from one slice to the next. A cycle counter tracks the slice position inside the group.

On the final slice of a group, the output is built combinationally. It is the accumulated total plus the current slice's lane sum, and `sum_valid` is high in that cycle. In the same cycle the accumulator reloads with zero, so the next group starts at once in the following cycle with no idle gap. The block accepts a slice on every cycle, so `in_ready` is held high. All addition wraps modulo 2^WIDTH.

Top module: `psum_reducer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator and the slice counter clear. The first cycle after reset is slice 0 of a group, and `sum_valid` is low in that cycle (assuming `TOTAL/LANES > 1`).
- R2: In slice `k` of a group, for k from 0 to `TOTAL/LANES-1`, `sum_valid` is high only when `k == TOTAL/LANES-1`.
- R3: In the final slice, `sum_out` equals the sum of every lane of every slice in the group, including the lanes presented in that same cycle.
- R4: All sums wrap modulo 2^WIDTH.
- R5: `in_ready` is high in every cycle after reset.
- R6: After a final slice, the next cycle is slice 0 of a new group whose sum starts from zero. Groups follow each other with no idle cycle.
- R7: Lane `i` occupies bits `[i*WIDTH +: WIDTH]` of `in_data`, and every lane adds to the sum with equal weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | LANES*WIDTH | Packed lanes of the current slice |
| in_ready | output | 1 | Slice accepted (always high) |
| sum_out | output | WIDTH | Group sum, meaningful when `sum_valid` is high |
| sum_valid | output | 1 | High on the final slice of each group |

## Verification
In the final slice, two things happen in the same cycle: the group result is presented, and the accumulator is cleared for the next group. The bench runs several groups back to back with varied and near-maximum lane values, so that wraparound occurs. A reference model keeps its own running total and slice count. It compares `sum_out` on each final slice, including that cycle's lanes, and checks that the first result after that slice contains no leftover from the previous group.

// File: rtl/psum_pkg.sv
// Shared helpers for the partial-sum reducer.
// Assumes: callers pass positive lane counts.
package psum_pkg;
    // Number of adder-tree levels needed to reduce n operands to one.
    function automatic int tree_levels(input int n);
        int lv;
        int cnt;
        lv  = 0;
        cnt = n;
        while (cnt > 1) begin
            cnt = (cnt + 1) / 2;
            lv++;
        end
        return lv;
    endfunction
endpackage

// File: rtl/psum_lane_tree.sv
// Combinational balanced adder tree over LANES operands of WIDTH bits.
// Assumes: LANES >= 1. Sums wrap modulo 2^WIDTH. Unused tree slots are fed zero.
module psum_lane_tree #(
    parameter int LANES = 3,
    parameter int WIDTH = 11
) (
    input  logic [LANES*WIDTH-1:0] lanes,
    output logic [WIDTH-1:0]       total
);
    localparam int LEVELS = psum_pkg::tree_levels(LANES);
    localparam int SLOTS  = 1 << LEVELS;

    logic [WIDTH-1:0] node [LEVELS+1][SLOTS];

    // Leaf level: place lanes, pad the remaining slots with zero.
    for (genvar i = 0; i < SLOTS; i++) begin : g_leaf
        if (i < LANES) begin : g_used
            assign node[0][i] = lanes[i*WIDTH +: WIDTH];
        end else begin : g_pad
            assign node[0][i] = '0;
        end
    end

    // Pairwise reduction, one level per generate pass.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar j = 0; j < SLOTS; j++) begin : g_node
            if (j < (SLOTS >> (l + 1))) begin : g_add
                assign node[l+1][j] = node[l][2*j] + node[l][2*j+1];
            end else begin : g_idle
                assign node[l+1][j] = '0;
            end
        end
    end

    assign total = node[LEVELS][0];
endmodule

// File: rtl/psum_slice_ctr.sv
// Counts slices within a group and flags the final one.
// Assumes: STEPS >= 1; counter wraps to zero after the final slice.
module psum_slice_ctr #(
    parameter int STEPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic last
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

    logic [CW-1:0] idx;

    // Advance the slice index each cycle, wrapping at the group end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (idx == LAST_IDX)
            idx <= '0;
        else
            idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

    // R6
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (idx == '0));
endmodule

// File: rtl/psum_accum.sv
// Running-total register across slices.
// Assumes: on the final slice the register reloads zero; otherwise it takes
// the stored total plus the slice sum.
module psum_accum #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last,
    input  logic [WIDTH-1:0] slice_sum,
    output logic [WIDTH-1:0] partial,
    output logic [WIDTH-1:0] running
);
    assign running = partial + slice_sum;

    // Hold the group's partial total, clearing on the final slice.
    always_ff @(posedge clk) begin
        if (!rst_n)
            partial <= '0;
        else if (last)
            partial <= '0;
        else
            partial <= running;
    end

    // R6
    clear_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (partial == '0));

    // R3
    carry_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> (partial == $past(partial) + $past(slice_sum)));
endmodule

// File: rtl/psum_reducer.sv
// Top: partially parallel sum reducer. LANES values per cycle, TOTAL per group.
// Assumes: TOTAL is a multiple of LANES; no downstream backpressure.
module psum_reducer #(
    parameter int TOTAL = 12,
    parameter int LANES = 3,
    parameter int WIDTH = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES*WIDTH-1:0] in_data,
    output logic                   in_ready,
    output logic [WIDTH-1:0]       sum_out,
    output logic                   sum_valid
);
    localparam int STEPS = TOTAL / LANES;

    logic             last;
    logic [WIDTH-1:0] slice_sum;
    logic [WIDTH-1:0] partial;
    logic [WIDTH-1:0] running;

    psum_lane_tree #(.LANES(LANES), .WIDTH(WIDTH)) u_tree (
        .lanes (in_data),
        .total (slice_sum)
    );

    psum_slice_ctr #(.STEPS(STEPS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .last  (last)
    );

    psum_accum #(.WIDTH(WIDTH)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .last      (last),
        .slice_sum (slice_sum),
        .partial   (partial),
        .running   (running)
    );

    // Present the running total; it is meaningful only on the final slice.
    always_comb begin
        sum_out   = running;
        sum_valid = last;
        in_ready  = 1'b1;
    end

    // R5
    ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready);

    // R2
    valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid && STEPS > 1) |=> !sum_valid);

    initial begin
        // R7
        lanes_divide_chk: assert (TOTAL % LANES == 0);
    end
endmodule

// File: tb/psum_reducer_bench.sv
module psum_reducer_bench;
    localparam int TOTAL = 12;
    localparam int LANES = 3;
    localparam int WIDTH = 11;
    localparam int STEPS = TOTAL / LANES;
    localparam int MASK  = (1 << WIDTH) - 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [LANES*WIDTH-1:0] in_data = '0;
    logic                   in_ready;
    logic [WIDTH-1:0]       sum_out;
    logic                   sum_valid;

    int checks = 0;
    int errors = 0;
    int ref_acc = 0;
    int ref_step = 0;
    int lane_q[$];

    always #2 clk = ~clk;

    psum_reducer #(.TOTAL(TOTAL), .LANES(LANES), .WIDTH(WIDTH)) u_psum_reducer (
        .clk (clk), .rst_n (rst_n), .in_data (in_data),
        .in_ready (in_ready), .sum_out (sum_out), .sum_valid (sum_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one slice before a rising edge, compare mid-cycle, update model.
    // mode 0: pattern from seed, 1: all max, 2: single lane hot
    task automatic slice(input int mode, input int seed);
        int s;
        for (int i = 0; i < LANES; i++) begin
            int v;
            if (mode == 1) v = MASK;
            else if (mode == 2) v = (i == seed % LANES) ? (seed * 37) & MASK : 0;
            else v = (seed * 97 + i * 413 + 5) & MASK;
            in_data[i*WIDTH +: WIDTH] = WIDTH'(v);
            lane_q.push_back(v);
        end
        #1;
        s = ref_acc;
        while (lane_q.size() > 0) s += lane_q.pop_front();
        s &= MASK;
        check("R5", int'(in_ready), 1);
        check("R2", int'(sum_valid), (ref_step == STEPS - 1) ? 1 : 0);
        if (ref_step == STEPS - 1) begin
            check("R3/R4/R7", int'(sum_out), s);
            ref_acc  = 0;
            ref_step = 0;
        end else begin
            ref_acc = s;
            ref_step++;
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: first cycle after reset is slice 0
        #0.5;
        check("R1", int'(sum_valid), 0);
        for (int g = 0; g < 3; g++)
            for (int k = 0; k < STEPS; k++) slice(0, g * 10 + k);
        // R4: wraparound with all-max lanes
        for (int k = 0; k < STEPS; k++) slice(1, 0);
        // R6: back-to-back group after max group starts from zero
        for (int k = 0; k < STEPS; k++) slice(2, k + 1);
        // R7: each lane weighted equally
        for (int g = 0; g < LANES; g++)
            for (int k = 0; k < STEPS; k++) slice(2, g + k * 0 + LANES * 0);
        // reset mid-group, R1
        slice(0, 77);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        ref_acc = 0;
        ref_step = 0;
        lane_q.delete();
        check("R1", int'(sum_valid), 0);
        for (int k = 0; k < STEPS; k++) slice(0, 200 + k);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule